// File: doc/BRIEF.md
# Dual-Mode Program Counter Sequencer

This block keeps the program counter of a core that can execute either a full-width instruction set with 4-byte instructions or a compact instruction set with 2-byte instructions. A second flag selects an alternate execution environment. The block holds the address of the current instruction, the address of the next one, the current mode flags and a pending copy of those flags. Each cycle the surrounding pipeline may write a branch target, change the pending flags, step the sequencer to the next instruction, or load a fresh PC.

A branch target can be written in one of three ways. A plain write aligns the target to the pending mode. An interworking write reads the low address bits to choose the next mode. A full-mode-only interworking write behaves as an interworking write only while both flags are clear. The block also holds a one-shot forced conditional-block state byte that is valid for exactly one step after it is written. It reports the PC value that instructions read as an operand, and it flags when the next PC is not the sequential successor.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the PC is 0, the next PC is 4, both current and both pending flags are 0, the forced value is 0 and not valid, and `branching` is 0.
- R2: A step (`advance`=1) with no target write moves the next PC into the PC and sets the new next PC to that address plus 2 if the compact flag after the step is 1, or plus 4 if it is 0.
- R3: `operandPc` equals the PC plus 4 while the compact flag is 1 and the PC plus 8 while it is 0.
- R4: On a step the current compact and environment flags take the values of the pending flags (including any pending change made in the same cycle).
- R5: A plain write (`wrKind`=1) stores the target as the next PC with bit 0 cleared when the pending compact flag is 1, or with bits 1:0 cleared when it is 0; the pending flags are unchanged.
- R6: An interworking write (`wrKind`=2, not in environment mode) with target bit 0 = 1 sets the pending compact flag and clears bit 0; with bits 1:0 = 00 it clears the pending compact flag and keeps the target; with bits 1:0 = 10 it keeps the pending compact flag and clears bits 1:0.
- R7: In environment mode (current compact and environment flags both 1) an interworking write only clears target bit 0 and leaves the pending flags unchanged.
- R8: A full-mode-only interworking write (`wrKind`=3) acts as an interworking write when both current flags are 0, and as a plain write otherwise.
- R9: Writing the forced value (`forceWr`) marks it not valid. On the next step a nonzero, not-valid value becomes valid and keeps its value; on any other step the value and its valid flag are both cleared.
- R10: `branching` is 1 exactly when the PC plus the current instruction size (2 in compact mode, 4 otherwise) differs from the next PC.
- R11: When a target write and a step occur in one cycle, the PC takes the aligned target and the next PC is the target plus the new instruction size. `pcLoad` sets the PC to `pcLoadVal` and the next PC to that value plus the current instruction size, and any step or target write in that cycle is ignored.
- R12: `pendWr` sets the pending flags from `pendCompactIn` and `pendEnvIn`. This takes effect before a target write in the same cycle, so the write's alignment and mode choice see the new pending values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcLoad | input | 1 | Load a fresh PC |
| pcLoadVal | input | ADDR_W | Value loaded on `pcLoad` |
| advance | input | 1 | Step to the next instruction |
| wrKind | input | 2 | Target write: 0 none, 1 plain, 2 interworking, 3 full-mode-only interworking |
| wrTarget | input | ADDR_W | Branch target address |
| pendWr | input | 1 | Write the pending flags |
| pendCompactIn | input | 1 | New pending compact flag |
| pendEnvIn | input | 1 | New pending environment flag |
| forceWr | input | 1 | Write the forced state value |
| forceVal | input | FORCE_W | Forced state value |
| pc | output | ADDR_W | Current instruction address |
| nextPc | output | ADDR_W | Next instruction address |
| operandPc | output | ADDR_W | PC value seen as an operand |
| compactMode | output | 1 | Current compact flag |
| envMode | output | 1 | Current environment flag |
| pendCompact | output | 1 | Pending compact flag |
| pendEnv | output | 1 | Pending environment flag |
| forcedVal | output | FORCE_W | Forced state value |
| forcedValid | output | 1 | Forced state value is valid |
| branching | output | 1 | Next PC is not the sequential successor |

## Verification
The embedded properties check several rules on every cycle. A step without a write hands the next PC to the PC, and a load takes its value. A plain full-width write leaves bits 1:0 clear, and an interworking write of a word-aligned target passes through unchanged. Environment-mode interworking never moves the pending mode, the current flags match the pending ones after a step, and a valid forced value lasts a single step. Only the bench's scenarios show the exact address arithmetic. These include compact and full increments, the operand offsets, each low-bit case of interworking, the full-mode-only write in every flag combination, the same-cycle write-and-step and load priority, and the `branching` output after taken and untaken changes.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;

  // Target write request as presented at the block edge
  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_PLAIN  = 2'd1,
    WK_IW     = 2'd2,
    WK_IWFULL = 2'd3
  } wrKind_e;

  // Resolved alignment / mode rule the datapath applies to a target
  typedef enum logic [1:0] {
    TM_PLAIN = 2'd0,
    TM_IW    = 2'd1,
    TM_IWENV = 2'd2
  } tgtMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadPc;
    logic     advance;
    logic     writeNpc;
    tgtMode_e tgtMode;
  } seqStrobes_t;

endpackage

// File: rtl/pcseq_forced.sv
`timescale 1ns/1ps
module pcseq_forced #(
  parameter int FORCE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               forceWr,
  input  logic [FORCE_W-1:0] forceVal,
  input  logic               advEff,
  output logic [FORCE_W-1:0] forcedVal,
  output logic               forcedValid
);

  logic [FORCE_W-1:0] valQ, valStaged, valNext;
  logic               vldQ, vldStaged, vldNext;

  // A write replaces the value and drops validity before any step is applied
  always_comb begin
    valStaged = forceWr ? forceVal : valQ;
    vldStaged = forceWr ? 1'b0 : vldQ;
    valNext   = valStaged;
    vldNext   = vldStaged;
    if (advEff) begin
      if ((valStaged != '0) && !vldStaged) begin
        vldNext = 1'b1;
      end else begin
        valNext = '0;
        vldNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valQ <= '0;
      vldQ <= 1'b0;
    end else begin
      valQ <= valNext;
      vldQ <= vldNext;
    end
  end

  assign forcedVal   = valQ;
  assign forcedValid = vldQ;

  AST_FORCE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (advEff && vldQ && !forceWr) |=> (!vldQ && valQ == '0)); // R9

  AST_FORCE_WR_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (forceWr && !advEff) |=> !vldQ); // R9

endmodule

// File: rtl/pcseq_control.sv
`timescale 1ns/1ps
module pcseq_control
  import pcseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pcLoad,
  input  logic        advance,
  input  logic [1:0]  wrKind,
  input  logic        pendWr,
  input  logic        pendCompactIn,
  input  logic        pendEnvIn,
  input  logic        hintToCompact,
  input  logic        hintToFull,
  output seqStrobes_t strobes,
  output logic        advEff,
  output logic        curCompact,
  output logic        curEnv,
  output logic        pendCompact,
  output logic        pendEnv,
  output logic        pendCompactPre,
  output logic        pendCompactPost
);

  logic     curCompactQ, curEnvQ, pendCompactQ, pendEnvQ;
  logic     pendEnvPre;
  wrKind_e  kindIn;
  logic     envActive, fullOnly;
  tgtMode_e modeSel;
  logic     writeReq;

  assign kindIn    = wrKind_e'(wrKind);
  assign envActive = curCompactQ && curEnvQ;
  assign fullOnly  = !curCompactQ && !curEnvQ;

  // Resolve the request into an alignment rule
  always_comb begin
    writeReq = 1'b0;
    modeSel  = TM_PLAIN;
    unique case (kindIn)
      WK_NONE: begin
        writeReq = 1'b0;
      end
      WK_PLAIN: begin
        writeReq = 1'b1;
        modeSel  = TM_PLAIN;
      end
      WK_IW: begin
        writeReq = 1'b1;
        modeSel  = envActive ? TM_IWENV : TM_IW;
      end
      WK_IWFULL: begin
        writeReq = 1'b1;
        modeSel  = fullOnly ? TM_IW : TM_PLAIN;
      end
      default: writeReq = 1'b0;
    endcase
  end

  // A load owns the cycle: no step and no target write
  always_comb begin
    strobes.loadPc   = pcLoad;
    strobes.advance  = advance && !pcLoad;
    strobes.writeNpc = writeReq && !pcLoad;
    strobes.tgtMode  = modeSel;
  end
  assign advEff = strobes.advance;

  // Pending flags: software write first, then interworking mode choice
  assign pendCompactPre = pendWr ? pendCompactIn : pendCompactQ;
  assign pendEnvPre     = pendWr ? pendEnvIn     : pendEnvQ;

  always_comb begin
    pendCompactPost = pendCompactPre;
    if (strobes.writeNpc && strobes.tgtMode == TM_IW) begin
      if (hintToCompact) begin
        pendCompactPost = 1'b1;
      end else if (hintToFull) begin
        pendCompactPost = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCompactQ  <= 1'b0;
      curEnvQ      <= 1'b0;
      pendCompactQ <= 1'b0;
      pendEnvQ     <= 1'b0;
    end else begin
      pendCompactQ <= pendCompactPost;
      pendEnvQ     <= pendEnvPre;
      if (strobes.advance) begin
        curCompactQ <= pendCompactPost;
        curEnvQ     <= pendEnvPre;
      end
    end
  end

  assign curCompact  = curCompactQ;
  assign curEnv      = curEnvQ;
  assign pendCompact = pendCompactQ;
  assign pendEnv     = pendEnvQ;

  AST_ENV_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeNpc && strobes.tgtMode == TM_IWENV && !pendWr)
      |=> (pendCompactQ == $past(pendCompactQ) && pendEnvQ == $past(pendEnvQ))); // R7

  AST_ADV_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    advEff |=> (curCompactQ == pendCompactQ && curEnvQ == pendEnvQ)); // R4

  AST_LOAD_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> (curCompactQ == $past(curCompactQ) && curEnvQ == $past(curEnvQ))); // R11

endmodule

// File: rtl/pcseq_datapath.sv
`timescale 1ns/1ps
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int COMPACT_BYTES = 2,
  parameter int FULL_BYTES    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrTarget,
  input  logic [ADDR_W-1:0] pcLoadVal,
  input  logic              curCompact,
  input  logic              pendCompactPre,
  input  logic              pendCompactPost,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] npcQ,
  output logic [ADDR_W-1:0] operandPc,
  output logic              branching,
  output logic              hintToCompact,
  output logic              hintToFull
);

  localparam logic [ADDR_W-1:0] STEP_C   = ADDR_W'(COMPACT_BYTES);
  localparam logic [ADDR_W-1:0] STEP_F   = ADDR_W'(FULL_BYTES);
  localparam logic [ADDR_W-1:0] OPND_C   = ADDR_W'(2 * COMPACT_BYTES);
  localparam logic [ADDR_W-1:0] OPND_F   = ADDR_W'(2 * FULL_BYTES);
  localparam logic [ADDR_W-1:0] MASK_C   = ~(ADDR_W'(COMPACT_BYTES - 1));
  localparam logic [ADDR_W-1:0] MASK_F   = ~(ADDR_W'(FULL_BYTES - 1));
  localparam logic [ADDR_W-1:0] RESET_NPC = STEP_F;

  logic [ADDR_W-1:0] alignedTgt, npcStaged;
  logic [ADDR_W-1:0] curStep, newStep;

  // Low target bits steer the interworking mode choice
  assign hintToCompact = wrTarget[0];
  assign hintToFull    = (wrTarget[1:0] == 2'b00);

  always_comb begin
    alignedTgt = wrTarget;
    unique case (strobes.tgtMode)
      TM_PLAIN: alignedTgt = wrTarget & (pendCompactPre ? MASK_C : MASK_F);
      TM_IW: begin
        if (wrTarget[0]) begin
          alignedTgt = wrTarget & MASK_C;
        end else if (wrTarget[1]) begin
          alignedTgt = wrTarget & MASK_F;
        end else begin
          alignedTgt = wrTarget;
        end
      end
      TM_IWENV: alignedTgt = wrTarget & MASK_C;
      default:  alignedTgt = wrTarget;
    endcase
  end

  assign npcStaged = strobes.writeNpc ? alignedTgt : npcQ;
  assign curStep   = curCompact ? STEP_C : STEP_F;
  assign newStep   = pendCompactPost ? STEP_C : STEP_F;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      npcQ <= RESET_NPC;
    end else if (strobes.loadPc) begin
      pcQ  <= pcLoadVal;
      npcQ <= pcLoadVal + curStep;
    end else if (strobes.advance) begin
      pcQ  <= npcStaged;
      npcQ <= npcStaged + newStep;
    end else begin
      npcQ <= npcStaged;
    end
  end

  assign operandPc = pcQ + (curCompact ? OPND_C : OPND_F);
  assign branching = (pcQ + curStep) != npcQ;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.writeNpc) |=> (pcQ == $past(npcQ))); // R2

  AST_LOAD_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPc |=> (pcQ == $past(pcLoadVal))); // R11

  AST_FULL_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeNpc && !strobes.advance && !strobes.loadPc &&
     strobes.tgtMode == TM_PLAIN && !pendCompactPre) |=> (npcQ[1:0] == 2'b00)); // R5

  AST_IW_WORD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeNpc && !strobes.advance && !strobes.loadPc &&
     strobes.tgtMode == TM_IW && wrTarget[1:0] == 2'b00) |=> (npcQ == $past(wrTarget))); // R6

endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FORCE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pcLoad,
  input  logic [ADDR_W-1:0]  pcLoadVal,
  input  logic               advance,
  input  logic [1:0]         wrKind,
  input  logic [ADDR_W-1:0]  wrTarget,
  input  logic               pendWr,
  input  logic               pendCompactIn,
  input  logic               pendEnvIn,
  input  logic               forceWr,
  input  logic [FORCE_W-1:0] forceVal,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  nextPc,
  output logic [ADDR_W-1:0]  operandPc,
  output logic               compactMode,
  output logic               envMode,
  output logic               pendCompact,
  output logic               pendEnv,
  output logic [FORCE_W-1:0] forcedVal,
  output logic               forcedValid,
  output logic               branching
);

  seqStrobes_t strobes;
  logic advEff, curCompact, pendCompactPre, pendCompactPost;
  logic hintToCompact, hintToFull;

  pcseq_control u_control (
    .clk             (clk),
    .rstN            (rstN),
    .pcLoad          (pcLoad),
    .advance         (advance),
    .wrKind          (wrKind),
    .pendWr          (pendWr),
    .pendCompactIn   (pendCompactIn),
    .pendEnvIn       (pendEnvIn),
    .hintToCompact   (hintToCompact),
    .hintToFull      (hintToFull),
    .strobes         (strobes),
    .advEff          (advEff),
    .curCompact      (curCompact),
    .curEnv          (envMode),
    .pendCompact     (pendCompact),
    .pendEnv         (pendEnv),
    .pendCompactPre  (pendCompactPre),
    .pendCompactPost (pendCompactPost)
  );

  pcseq_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .wrTarget        (wrTarget),
    .pcLoadVal       (pcLoadVal),
    .curCompact      (curCompact),
    .pendCompactPre  (pendCompactPre),
    .pendCompactPost (pendCompactPost),
    .pcQ             (pc),
    .npcQ            (nextPc),
    .operandPc       (operandPc),
    .branching       (branching),
    .hintToCompact   (hintToCompact),
    .hintToFull      (hintToFull)
  );

  pcseq_forced #(.FORCE_W(FORCE_W)) u_forced (
    .clk         (clk),
    .rstN        (rstN),
    .forceWr     (forceWr),
    .forceVal    (forceVal),
    .advEff      (advEff),
    .forcedVal   (forcedVal),
    .forcedValid (forcedValid)
  );

  assign compactMode = curCompact;

endmodule

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pcLoad = 1'b0;
  logic [31:0] pcLoadVal = '0;
  logic        advance = 1'b0;
  logic [1:0]  wrKind = 2'd0;
  logic [31:0] wrTarget = '0;
  logic        pendWr = 1'b0, pendCompactIn = 1'b0, pendEnvIn = 1'b0;
  logic        forceWr = 1'b0;
  logic [7:0]  forceVal = '0;
  logic [31:0] pc, nextPc, operandPc;
  logic        compactMode, envMode, pendCompact, pendEnv, forcedValid, branching;
  logic [7:0]  forcedVal;

  always #4 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rstN(rstN), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
    .advance(advance), .wrKind(wrKind), .wrTarget(wrTarget),
    .pendWr(pendWr), .pendCompactIn(pendCompactIn), .pendEnvIn(pendEnvIn),
    .forceWr(forceWr), .forceVal(forceVal),
    .pc(pc), .nextPc(nextPc), .operandPc(operandPc),
    .compactMode(compactMode), .envMode(envMode),
    .pendCompact(pendCompact), .pendEnv(pendEnv),
    .forcedVal(forcedVal), .forcedValid(forcedValid), .branching(branching)
  );

  typedef struct {
    string       tag;
    logic [31:0] pc, npc, opnd;
    logic        c, e, pcm, pen, fvd, br;
    logic [7:0]  fv;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // Bench model state
  logic [31:0] mPc = 32'd0, mNpc = 32'd4;
  logic mC = 0, mE = 0, mPC = 0, mPE = 0, mFvd = 0;
  logic [7:0] mFv = 8'd0;

  function automatic expItem_t snap(string tag);
    expItem_t it;
    it.tag = tag; it.pc = mPc; it.npc = mNpc;
    it.opnd = mPc + (mC ? 32'd4 : 32'd8);
    it.c = mC; it.e = mE; it.pcm = mPC; it.pen = mPE;
    it.fv = mFv; it.fvd = mFvd;
    it.br = ((mPc + (mC ? 32'd2 : 32'd4)) != mNpc);
    return it;
  endfunction

  task automatic modelStep(bit ld, logic [31:0] ldv, bit adv, logic [1:0] kind,
                           logic [31:0] tgt, bit pw, bit pcIn, bit peIn,
                           bit fw, logic [7:0] fv);
    logic p0, e0, p1;
    logic [31:0] n1, v0;
    int mode; // 0 none, 1 plain, 2 iw, 3 env-iw
    bit d0, advE;
    p0 = pw ? pcIn : mPC;
    e0 = pw ? peIn : mPE;
    p1 = p0;
    n1 = mNpc;
    mode = 0;
    if (!ld) begin
      if (kind == 2'd1) mode = 1;
      else if (kind == 2'd2) mode = (mC && mE) ? 3 : 2;
      else if (kind == 2'd3) mode = (!mC && !mE) ? 2 : 1;
    end
    if (mode == 1) n1 = p0 ? (tgt & ~32'd1) : (tgt & ~32'd3);
    else if (mode == 3) n1 = tgt & ~32'd1;
    else if (mode == 2) begin
      if (tgt[0]) begin p1 = 1'b1; n1 = tgt & ~32'd1; end
      else if (!tgt[1]) begin p1 = 1'b0; n1 = tgt; end
      else n1 = tgt & ~32'd3;
    end
    advE = adv && !ld;
    if (ld) begin
      mPc = ldv; mNpc = ldv + (mC ? 32'd2 : 32'd4);
    end else if (advE) begin
      mPc = n1; mNpc = n1 + (p1 ? 32'd2 : 32'd4); mC = p1; mE = e0;
    end else begin
      mNpc = n1;
    end
    mPC = p1; mPE = e0;
    v0 = fw ? {24'd0, fv} : {24'd0, mFv};
    d0 = fw ? 1'b0 : mFvd;
    if (advE) begin
      if (v0[7:0] != 8'd0 && !d0) begin mFv = v0[7:0]; mFvd = 1'b1; end
      else begin mFv = 8'd0; mFvd = 1'b0; end
    end else begin
      mFv = v0[7:0]; mFvd = d0;
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic op(string tag, bit ld, logic [31:0] ldv, bit adv, logic [1:0] kind,
                    logic [31:0] tgt, bit pw, bit pcIn, bit peIn,
                    bit fw, logic [7:0] fv);
    @(negedge clk);
    pcLoad = ld; pcLoadVal = ldv; advance = adv; wrKind = kind; wrTarget = tgt;
    pendWr = pw; pendCompactIn = pcIn; pendEnvIn = peIn; forceWr = fw; forceVal = fv;
    @(posedge clk);
    #1;
    pcLoad = 0; advance = 0; wrKind = 2'd0; pendWr = 0; forceWr = 0;
    modelStep(ld, ldv, adv, kind, tgt, pw, pcIn, peIn, fw, fv);
    expQ.push_back(snap(tag));
  endtask

  task automatic stepOnly(string tag);
    op(tag, 0, 0, 1, 2'd0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(string tag, logic [1:0] kind, logic [31:0] tgt, bit adv);
    op(tag, 0, 0, adv, kind, tgt, 0, 0, 0, 0, 0);
  endtask
  task automatic setPend(string tag, bit c, bit e);
    op(tag, 0, 0, 0, 2'd0, 0, 1, c, e, 0, 0);
  endtask
  task automatic force8(string tag, logic [7:0] v, bit adv);
    op(tag, 0, 0, adv, 2'd0, 0, 0, 0, 0, 1, v);
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (pc !== it.pc || nextPc !== it.npc || operandPc !== it.opnd ||
            compactMode !== it.c || envMode !== it.e || pendCompact !== it.pcm ||
            pendEnv !== it.pen || forcedVal !== it.fv || forcedValid !== it.fvd ||
            branching !== it.br) begin
          fails++;
          $display("FAIL %s: actual pc=%h npc=%h opnd=%h c=%b e=%b pc=%b pe=%b fv=%h fvd=%b br=%b expected pc=%h npc=%h opnd=%h c=%b e=%b pc=%b pe=%b fv=%h fvd=%b br=%b",
                   it.tag, pc, nextPc, operandPc, compactMode, envMode, pendCompact,
                   pendEnv, forcedVal, forcedValid, branching,
                   it.pc, it.npc, it.opnd, it.c, it.e, it.pcm, it.pen, it.fv, it.fvd, it.br);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expQ.push_back(snap("R1 reset state"));
    @(negedge clk);

    // Full-width sequential steps
    stepOnly("R2 R3 full step 1");
    stepOnly("R2 R3 full step 2");
    // Plain writes in full pending mode, then step
    wr("R5 R10 plain full align", 2'd1, 32'h0000_1003, 0);
    stepOnly("R2 step to target");
    // Pending compact flag, plain write in same cycle sees it
    op("R12 R5 pend compact + plain", 0, 0, 0, 2'd1, 32'h0000_2003, 1, 1, 0, 0, 0);
    stepOnly("R4 R2 R3 enter compact");
    stepOnly("R2 compact step");
    // Interworking low-bit cases
    wr("R6 iw bit0 to compact", 2'd2, 32'h0000_3001, 0);
    wr("R6 iw 00 to full", 2'd2, 32'h0000_4000, 0);
    wr("R6 iw 10 keep mode", 2'd2, 32'h0000_4006, 0);
    stepOnly("R4 leave compact");
    // Same-cycle write and step
    wr("R11 write+step", 2'd2, 32'h0000_5001, 1);
    stepOnly("R2 compact after iw");
    // Load priority over step and write
    op("R11 load overrides", 1, 32'h0000_8000, 1, 2'd1, 32'h0000_9000, 0, 0, 0, 0, 0);
    // Environment mode
    setPend("R12 pend env", 1, 1);
    stepOnly("R4 enter env mode");
    wr("R7 env iw word kept", 2'd2, 32'h0000_A000, 0);
    wr("R7 env iw bit0 cleared", 2'd2, 32'h0000_A003, 0);
    wr("R8 full-only in env acts plain", 2'd3, 32'h0000_B003, 0);
    // Back to full mode, full-only interworking active
    setPend("R12 pend full", 0, 0);
    stepOnly("R4 leave env");
    wr("R8 full-only iw to compact", 2'd3, 32'h0000_C005, 0);
    setPend("R12 pend compact only", 1, 0);
    stepOnly("R4 compact no env");
    wr("R8 full-only in compact acts plain", 2'd3, 32'h0000_D001, 0);
    wr("R6 iw compact not env", 2'd2, 32'h0000_D00A, 0);
    stepOnly("R2 R10 step after iw");
    // Forced state one-shot
    force8("R9 force write invalid", 8'h5A, 0);
    stepOnly("R9 force becomes valid");
    stepOnly("R9 force cleared");
    force8("R9 zero force", 8'h00, 0);
    stepOnly("R9 zero stays invalid");
    force8("R9 force with step", 8'h33, 1);
    force8("R9 rewrite while valid", 8'h44, 0);
    stepOnly("R9 rewrite becomes valid");
    stepOnly("R9 cleared again");
    wr("R10 branching untaken write", 2'd1, 32'h0000_0000, 0);
    stepOnly("R10 after step");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule